// File: doc/BRIEF.md
# Monotonic Oscillator Trim Calibrator

This block sets the 8-bit capacitor-array code that trims a sensing oscillator. A beat-period counter outside the block measures the period of the mixer output, and the block compares each measurement with a programmed target period code. A `start` pulse loads the target and resets the trim code to zero, which is the fastest oscillator setting and so the highest beat frequency. The block then adds a share of each positive error to the code. The code therefore only ever rises, and the beat frequency falls toward the target from above.

Movement is one-directional for a reason. The mixer reports only the magnitude of the frequency difference. If the divided oscillator dropped below the reference, the error would change meaning and the loop would run away. Calibration therefore ends on the first sample whose period has reached or passed the target, or when the code hits full scale. Reaching full scale also raises a range error.

Measurements arrive on a valid/ready stream. `meas_ready` is high only while calibration runs. A sample is consumed in a cycle where both `meas_valid` and `meas_ready` are high. While the block is idle, samples are not consumed, so a producer must hold them or drop them. After every change of the code, one consumed sample is thrown away so that the oscillator can settle.

Top module: `freq_trim_ctrl`

## Requirements
- R1: After reset, `trim_code` is 0 and `busy`, `done`, `range_err` and `meas_ready` are all 0.
- R2: A `start` pulse while `busy` is 0 does the following in the next cycle: `trim_code` goes to 0, `busy` rises, `done` and `range_err` clear, and `target_code` is captured. A `start` pulse while `busy` is 1 has no effect.
- R3: `meas_ready` equals `busy`. A measurement is consumed only in a cycle with `meas_valid` and `meas_ready` both high. While the block is idle, a valid measurement changes nothing.
- R4: The first sample consumed after `start`, and the first sample consumed after each change of the code, is discarded. Such a sample does not change the code or end calibration.
- R5: For an evaluated sample, error = captured target − measured code. If the error is positive, `trim_code` rises by max(error >> 2, 1) in the next cycle. The step is capped at 255.
- R6: While `busy` is high, `trim_code` never decreases from one cycle to the next.
- R7: If an evaluated error is zero or negative, then in the next cycle `busy` falls and `done` rises, and `trim_code` is unchanged.
- R8: If code + step would be 255 or more, then in the next cycle `trim_code` is 255, and `done` and `range_err` rise together while `busy` falls.
- R9: `done` and `range_err` hold their values until the next accepted `start`, and `done` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (ignored while busy) |
| target_code | input | 12 | Target beat-period code, captured at start |
| meas_code | input | 12 | Measured beat-period code |
| meas_valid | input | 1 | Measurement stream valid |
| meas_ready | output | 1 | Measurement stream ready (high while busy) |
| trim_code | output | 8 | Capacitor-array trim code |
| busy | output | 1 | Calibration running |
| done | output | 1 | Calibration finished |
| range_err | output | 1 | Finished because the code reached full scale |

## Verification
Two functions can coincide in one cycle. The first is the step that saturates the code and the end of calibration. The bench provokes this with a run whose accumulated steps overshoot 255, and with a single huge error whose step is capped. It then judges that `trim_code`, `done`, `range_err` and the fall of `busy` all appear on the same edge. The second is `start` arriving in the same cycle as a valid measurement while the block is idle. That sample must not be consumed, and the next consumed sample must be treated as the settle sample. A scoreboard predicts every change of the code and compares each change as it happens.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SETTLE = 2'd1,
    CAL_EVAL   = 2'd2
  } cal_state_e;
endpackage

// File: rtl/cal_step_calc.sv
module cal_step_calc #(
  parameter int MEAS_W = 12,
  parameter int CODE_W = 8,
  parameter int SHIFT  = 2
) (
  input  logic [MEAS_W-1:0] tgt,
  input  logic [MEAS_W-1:0] meas,
  output logic              err_pos,
  output logic [CODE_W-1:0] step
);
  localparam logic [MEAS_W-1:0] CAP = MEAS_W'((1 << CODE_W) - 1);

  logic [MEAS_W:0]   diff;
  logic [MEAS_W-1:0] shifted;

  always_comb begin
    diff    = {1'b0, tgt} - {1'b0, meas};
    err_pos = !diff[MEAS_W] && (diff != '0);
    shifted = diff[MEAS_W-1:0] >> SHIFT;
    if (shifted == '0)
      step = CODE_W'(1);
    else if (shifted > CAP)
      step = '1;
    else
      step = shifted[CODE_W-1:0];
  end
endmodule

// File: rtl/cal_trim_accum.sv
module cal_trim_accum #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              apply,
  input  logic [CODE_W-1:0] step,
  output logic [CODE_W-1:0] trim,
  output logic              will_sat
);
  localparam logic [CODE_W:0] FULL = {1'b0, {CODE_W{1'b1}}};

  logic [CODE_W:0] sum;

  always_comb begin
    sum      = {1'b0, trim} + {1'b0, step};
    will_sat = (sum >= FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trim <= '0;
    else if (clear)
      trim <= '0;
    else if (apply)
      trim <= will_sat ? FULL[CODE_W-1:0] : sum[CODE_W-1:0];
  end
endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import cal_pkg::*;
#(
  parameter int MEAS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEAS_W-1:0] target_code,
  input  logic              meas_valid,
  input  logic              err_pos,
  input  logic              will_sat,
  output logic              meas_ready,
  output logic              busy,
  output logic              done,
  output logic              range_err,
  output logic [MEAS_W-1:0] tgt_q,
  output logic              clear,
  output logic              apply,
  output logic              eval_take
);
  cal_state_e state, state_n;
  logic take;

  always_comb begin
    busy       = (state != CAL_IDLE);
    meas_ready = busy;
    take       = meas_valid && meas_ready;
    eval_take  = (state == CAL_EVAL) && take;
    clear      = (state == CAL_IDLE) && start;
    apply      = eval_take && err_pos;
    state_n    = state;
    case (state)
      CAL_IDLE:   if (start) state_n = CAL_SETTLE;
      CAL_SETTLE: if (take)  state_n = CAL_EVAL;
      CAL_EVAL: begin
        if (take) begin
          if (!err_pos || will_sat) state_n = CAL_IDLE;
          else                      state_n = CAL_SETTLE;
        end
      end
      default:    state_n = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CAL_IDLE;
      done      <= 1'b0;
      range_err <= 1'b0;
      tgt_q     <= '0;
    end else begin
      state <= state_n;
      if (clear) begin
        done      <= 1'b0;
        range_err <= 1'b0;
        tgt_q     <= target_code;
      end else if (eval_take) begin
        if (!err_pos) begin
          done <= 1'b1;
        end else if (will_sat) begin
          done      <= 1'b1;
          range_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/freq_trim_ctrl.sv
module freq_trim_ctrl #(
  parameter int MEAS_W = 12,
  parameter int CODE_W = 8,
  parameter int SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEAS_W-1:0] target_code,
  input  logic [MEAS_W-1:0] meas_code,
  input  logic              meas_valid,
  output logic              meas_ready,
  output logic [CODE_W-1:0] trim_code,
  output logic              busy,
  output logic              done,
  output logic              range_err
);
  logic [MEAS_W-1:0] tgt_q;
  logic [CODE_W-1:0] step;
  logic              err_pos, will_sat, clear, apply, eval_take;

  cal_step_calc #(.MEAS_W(MEAS_W), .CODE_W(CODE_W), .SHIFT(SHIFT)) u_step (
    .tgt(tgt_q), .meas(meas_code), .err_pos(err_pos), .step(step)
  );

  cal_trim_accum #(.CODE_W(CODE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .apply(apply),
    .step(step), .trim(trim_code), .will_sat(will_sat)
  );

  cal_seq_fsm #(.MEAS_W(MEAS_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .target_code(target_code),
    .meas_valid(meas_valid), .err_pos(err_pos), .will_sat(will_sat),
    .meas_ready(meas_ready), .busy(busy), .done(done), .range_err(range_err),
    .tgt_q(tgt_q), .clear(clear), .apply(apply), .eval_take(eval_take)
  );
endmodule

// File: rtl/cal_trim_checker.sv
module cal_trim_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              meas_valid,
  input logic              meas_ready,
  input logic              busy,
  input logic              done,
  input logic              range_err,
  input logic [CODE_W-1:0] trim_code,
  input logic              eval_take,
  input logic              err_pos
);
  a_r6_trim_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> trim_code >= $past(trim_code));

  a_r5_step_raises: assert property (@(posedge clk) disable iff (!rst_n)
    eval_take && err_pos |=> trim_code > $past(trim_code));

  a_r7_stop_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
    eval_take && !err_pos |=> done && !busy && $stable(trim_code));

  a_r8_range_full: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> done && (trim_code == {CODE_W{1'b1}}));

  a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done && !range_err && (trim_code == '0));

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_hold_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_valid && meas_ready) && !start |=> $stable(trim_code));
endmodule

bind freq_trim_ctrl cal_trim_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .meas_valid(meas_valid),
  .meas_ready(meas_ready), .busy(busy), .done(done), .range_err(range_err),
  .trim_code(trim_code), .eval_take(eval_take), .err_pos(err_pos)
);

// File: tb/tb_freq_trim_ctrl.sv
module tb_freq_trim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] target_code = '0;
  logic [11:0] meas_code = '0;
  logic        meas_valid = 1'b0;
  logic        meas_ready, busy, done, range_err;
  logic [7:0]  trim_code;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model
  int m_trim = 0, m_tgt = 0;
  bit m_busy = 0, m_skip = 0, m_done = 0, m_rng = 0;
  int exp_q[$];
  logic [7:0] last_trim = '0;

  always #2.5 clk = ~clk;

  freq_trim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_code(target_code),
    .meas_code(meas_code), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .trim_code(trim_code), .busy(busy), .done(done), .range_err(range_err)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_sample(int meas);
    int err, st, s;
    if (!m_busy) return;
    if (m_skip) begin m_skip = 0; return; end
    err = m_tgt - meas;
    if (err <= 0) begin
      m_busy = 0; m_done = 1;
    end else begin
      st = err >>> 2;
      if (st < 1) st = 1;
      if (st > 255) st = 255;
      s = m_trim + st;
      if (s >= 255) begin
        m_trim = 255; m_busy = 0; m_done = 1; m_rng = 1;
      end else begin
        m_trim = s; m_skip = 1;
      end
      exp_q.push_back(m_trim);
    end
  endtask

  task automatic model_start(int tgt);
    if (m_busy) return;
    if (m_trim != 0) exp_q.push_back(0);
    m_trim = 0; m_busy = 1; m_skip = 1; m_tgt = tgt; m_done = 0; m_rng = 0;
  endtask

  // driver: one transaction, outputs settled at return
  task automatic send(int meas);
    @(negedge clk);
    meas_valid = 1'b1;
    meas_code  = 12'(meas);
    model_sample(meas);
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic do_start(int tgt);
    @(negedge clk);
    start = 1'b1;
    target_code = 12'(tgt);
    model_start(tgt);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic status(string req);
    check({req, " trim"}, int'(trim_code), m_trim);
    check({req, " busy"}, int'(busy), int'(m_busy));
    check({req, " done"}, int'(done), int'(m_done));
    check({req, " range_err"}, int'(range_err), int'(m_rng));
    check({req, " ready"}, int'(meas_ready), int'(m_busy));
  endtask

  // monitor: each change of the code must match the next predicted value
  always @(negedge clk) begin
    if (rst_n && trim_code != last_trim) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected trim change", int'(trim_code), int'(last_trim));
      end else begin
        check("R5 scoreboard trim", int'(trim_code), exp_q.pop_front());
      end
      last_trim = trim_code;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    status("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3: idle sample is not consumed
    send(50);
    status("R3 idle sample");

    // normal convergence from above
    do_start(400);
    status("R2 start");
    send(100);
    status("R4 settle discard");
    send(100);                 // err 300 -> step 75
    status("R5 step 75");
    send(200);                 // discarded
    send(200);                 // err 200 -> step 50
    status("R5 step 50");
    send(398); send(398);      // err 2 -> minimum step 1
    status("R5 min step");
    send(400); send(400);      // err 0 -> stop
    status("R7 zero error stop");
    send(10);
    status("R9 done holds");

    // start ignored while busy; R6 no drop
    do_start(1000);
    send(900); send(900);      // step 25
    do_start(10);              // ignored
    status("R2 start while busy");
    send(900); send(1000);
    status("R7 stop after ignored start");

    // saturation through accumulation
    do_start(1000);
    for (int i = 0; i < 5; i++) begin
      send(760); send(760);
    end
    status("R8 accumulate to full");
    send(0);
    status("R3 idle after range");

    // negative error ends at once, flags cleared by start
    do_start(100);
    status("R9 start clears flags");
    send(500); send(500);
    status("R7 negative error");

    // huge error, step capped, saturate in one step
    do_start(4000);
    send(0); send(0);
    status("R8 capped step");

    // start together with a valid sample while idle
    @(negedge clk);
    start = 1'b1; target_code = 12'd300;
    meas_valid = 1'b1; meas_code = 12'd0;
    model_start(300);
    @(negedge clk);
    start = 1'b0; meas_valid = 1'b0;
    status("R3 start with sample");
    send(200);                 // settle discard
    status("R4 discard after start");
    send(200);                 // err 100 -> step 25
    status("R5 step after start");

    repeat (3) @(negedge clk);
    check("R5 scoreboard empty", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule